// File: doc/BRIEF.md
# Reorder Buffer with Misprediction Recovery

This block keeps the program order of in-flight instructions. Each dispatched instruction takes the next slot of a circular buffer and receives that slot's index as its tag. Execution units return results out of order by naming the slot. The buffer retires from the oldest slot and only when that slot is finished, so the program-visible state always changes in program order.

The block also owns two rename tables. The speculative table maps each architectural register to the newest physical tag handed out. The committed table changes only at retirement. Every branch takes a snapshot of the speculative table when it is allocated. When a branch reports a wrong prediction, every younger slot is dropped in one cycle and the speculative table is reloaded from that branch's snapshot. A store writes memory only when it retires, so a store on the wrong path disappears without a trace.

Top module: `rob_recover`

## Requirements
- R1: After reset the buffer is empty, allocation is accepted, nothing retires, and both rename tables map architectural register n to physical tag n.
- R2: Allocation is accepted when the buffer is not full, no recovery is happening in this cycle, and (for a branch) a snapshot slot is free. Kind encoding: 0 = register-writing op, 1 = branch, 2 = store. The tag returned is the tail index, and tags advance 0,1,...,DEPTH-1 and then wrap to 0.
- R3: At most one slot retires per cycle, always the head, and only once its completion has arrived. It reports the kind, the destination register, the new tag and the tag it displaced.
- R4: The memory-write strobe is high only in the cycle a store retires, for exactly that cycle, and it carries the store's slot index.
- R5: A completion that names a live branch with the mispredict flag set drops every younger slot in that cycle and raises the recovery output. The next allocation takes the slot right after the branch, and the branch and all older slots still retire.
- R6: During recovery the speculative table returns to its contents at the branch's allocation, and allocation is refused in that cycle.
- R7: The committed table changes only when a register-writing op retires, and then takes that op's new tag.
- R8: A completion that names a dropped or empty slot has no effect. A later instruction that reuses the slot does not retire until its own completion arrives.
- R9: A branch cannot be allocated while every snapshot slot is held by a live branch. A non-branch allocation still proceeds.
- R10: A full buffer, where head and tail indices are equal, is told apart from an empty one by a wrap bit. When full it refuses allocation. When empty it retires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch request |
| alloc_kind | input | 2 | 0 register op, 1 branch, 2 store |
| alloc_areg | input | AW | Destination architectural register |
| alloc_ptag | input | PTAG_W | New physical tag for the destination |
| alloc_ready | output | 1 | Request accepted this cycle |
| alloc_idx | output | IW | Slot given to the request |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | IW | Slot being completed |
| cmpl_mispred | input | 1 | Branch resolved against its prediction |
| retire_valid | output | 1 | Head slot retires this cycle |
| retire_kind | output | 2 | Kind of retiring slot |
| retire_areg | output | AW | Its destination register |
| retire_ptag | output | PTAG_W | Its new physical tag |
| retire_prev_ptag | output | PTAG_W | Tag it displaced, free for reuse |
| retire_mispred | output | 1 | Retiring branch was mispredicted |
| mem_wr_en | output | 1 | Store release strobe |
| mem_wr_idx | output | IW | Slot of the released store |
| flush_out | output | 1 | Recovery in this cycle |
| spec_rd_areg | input | AW | Speculative table read address |
| spec_rd_ptag | output | PTAG_W | Speculative table read data |
| cmt_rd_areg | input | AW | Committed table read address |
| cmt_rd_ptag | output | PTAG_W | Committed table read data |

## Verification
The bench builds the block with its defaults: six slots, eight architectural registers, four-bit physical tags and two snapshot slots. Because six is not a power of two, the pointers wrap explicitly, and the bench reaches that path many times. With only two snapshot slots, branch stalls are frequent under random traffic, and the bench can reach a recovery in which a younger branch's snapshot is released at the same moment an older branch's is restored. A reference model in the bench reads both rename tables every cycle through the read ports, so a wrong restore or an early commit shows up in the cycle where it happens.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        OP_REG    = 2'd0,
        OP_BRANCH = 2'd1,
        OP_STORE  = 2'd2
    } op_kind_e;
endpackage

// File: rtl/rob_ckpt_pool.sv
// Pool of rename-snapshot slots; hands out the lowest free slot.
module rob_ckpt_pool #(
    parameter int NCKPT = 2,
    parameter int CW    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [NCKPT-1:0] free_mask,
    output logic             avail,
    output logic [CW-1:0]    slot
);
    logic [NCKPT-1:0] busy_q;
    logic [NCKPT-1:0] take_mask;

    always_comb begin
        avail = 1'b0;
        slot  = '0;
        for (int i = NCKPT - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                avail = 1'b1;
                slot  = CW'(i);
            end
        end
    end

    always_comb begin
        take_mask = '0;
        if (take && avail) begin
            take_mask[slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~free_mask) | take_mask;
        end
    end
endmodule

// File: rtl/rob_rename_maps.sv
// Speculative and committed rename tables plus branch snapshots.
module rob_rename_maps #(
    parameter int AREGS  = 8,
    parameter int PTAG_W = 4,
    parameter int NCKPT  = 2,
    parameter int AW     = 3,
    parameter int CW     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_en,
    input  logic [AW-1:0]     ren_areg,
    input  logic [PTAG_W-1:0] ren_ptag,
    output logic [PTAG_W-1:0] ren_prev,
    input  logic              save_en,
    input  logic [CW-1:0]     save_slot,
    input  logic              restore_en,
    input  logic [CW-1:0]     restore_slot,
    input  logic              cmt_en,
    input  logic [AW-1:0]     cmt_areg,
    input  logic [PTAG_W-1:0] cmt_ptag,
    input  logic [AW-1:0]     spec_rd_areg,
    output logic [PTAG_W-1:0] spec_rd_ptag,
    input  logic [AW-1:0]     cmt_rd_areg,
    output logic [PTAG_W-1:0] cmt_rd_ptag
);
    logic [AREGS-1:0][PTAG_W-1:0]            spec_map;
    logic [AREGS-1:0][PTAG_W-1:0]            cmt_map;
    logic [NCKPT-1:0][AREGS-1:0][PTAG_W-1:0] snap;

    assign ren_prev     = spec_map[ren_areg];
    assign spec_rd_ptag = spec_map[spec_rd_areg];
    assign cmt_rd_ptag  = cmt_map[cmt_rd_areg];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < AREGS; a++) begin
                spec_map[a] <= PTAG_W'(a);
            end
        end else if (restore_en) begin
            spec_map <= snap[restore_slot];
        end else if (ren_en) begin
            spec_map[ren_areg] <= ren_ptag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < AREGS; a++) begin
                cmt_map[a] <= PTAG_W'(a);
            end
        end else if (cmt_en) begin
            cmt_map[cmt_areg] <= cmt_ptag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (save_en) begin
            snap[save_slot] <= spec_map;
        end
    end
endmodule

// File: rtl/rob_recover.sv
// Circular reorder buffer with single-cycle flush of wrong-path slots.
module rob_recover
    import rob_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int AREGS  = 8,
    parameter int PTAG_W = 4,
    parameter int NCKPT  = 2,
    localparam int IW = $clog2(DEPTH),
    localparam int AW = $clog2(AREGS),
    localparam int CW = (NCKPT > 1) ? $clog2(NCKPT) : 1,
    localparam int PW = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [AW-1:0]     alloc_areg,
    input  logic [PTAG_W-1:0] alloc_ptag,
    output logic              alloc_ready,
    output logic [IW-1:0]     alloc_idx,
    input  logic              cmpl_valid,
    input  logic [IW-1:0]     cmpl_idx,
    input  logic              cmpl_mispred,
    output logic              retire_valid,
    output logic [1:0]        retire_kind,
    output logic [AW-1:0]     retire_areg,
    output logic [PTAG_W-1:0] retire_ptag,
    output logic [PTAG_W-1:0] retire_prev_ptag,
    output logic              retire_mispred,
    output logic              mem_wr_en,
    output logic [IW-1:0]     mem_wr_idx,
    output logic              flush_out,
    input  logic [AW-1:0]     spec_rd_areg,
    output logic [PTAG_W-1:0] spec_rd_ptag,
    input  logic [AW-1:0]     cmt_rd_areg,
    output logic [PTAG_W-1:0] cmt_rd_ptag
);
    // pointer = {wrap bit, slot index}
    logic [PW-1:0] head_q, tail_q, head_d, tail_d;
    logic [IW-1:0] head_idx, tail_idx;

    logic [DEPTH-1:0]             e_valid, e_done, e_mis;
    op_kind_e [DEPTH-1:0]         e_kind;
    logic [DEPTH-1:0][AW-1:0]     e_areg;
    logic [DEPTH-1:0][PTAG_W-1:0] e_ptag, e_prev;
    logic [DEPTH-1:0][CW-1:0]     e_ckpt;

    logic             full, cmpl_live, flush, retire_fire;
    logic             alloc_fire, is_branch_req;
    logic             br_wrap;
    logic [PW-1:0]    br_age;
    logic [DEPTH-1:0] kill;
    logic             ck_avail;
    logic [CW-1:0]    ck_slot;
    logic [NCKPT-1:0] ck_free;
    logic [PTAG_W-1:0] ren_prev;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        if (p[IW-1:0] == IW'(DEPTH - 1)) begin
            return {~p[IW], {IW{1'b0}}};
        end
        return {p[IW], p[IW-1:0] + IW'(1)};
    endfunction

    // distance of a slot from the head, in program order
    function automatic logic [PW-1:0] age_of(input logic [IW-1:0] idx,
                                             input logic [IW-1:0] hd);
        if (idx >= hd) begin
            return {1'b0, idx} - {1'b0, hd};
        end
        return ({1'b0, idx} + PW'(DEPTH)) - {1'b0, hd};
    endfunction

    assign head_idx = head_q[IW-1:0];
    assign tail_idx = tail_q[IW-1:0];

    // ---------------- control ----------------
    always_comb begin
        full        = (head_idx == tail_idx) && (head_q[IW] != tail_q[IW]);
        cmpl_live   = cmpl_valid && ({1'b0, cmpl_idx} < PW'(DEPTH)) && e_valid[cmpl_idx];
        flush       = cmpl_live && cmpl_mispred && (e_kind[cmpl_idx] == OP_BRANCH);
        br_age      = age_of(cmpl_idx, head_idx);
        br_wrap     = (cmpl_idx >= head_idx) ? head_q[IW] : ~head_q[IW];
        retire_fire = e_valid[head_idx] && e_done[head_idx];
        is_branch_req = (alloc_kind == 2'(OP_BRANCH));
        alloc_ready = !full && !flush && (!is_branch_req || ck_avail);
        alloc_fire  = alloc_valid && alloc_ready;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_kill
        assign kill[g] = flush && e_valid[g] && (age_of(IW'(g), head_idx) > br_age);
    end

    always_comb begin
        ck_free = '0;
        if (retire_fire && e_kind[head_idx] == OP_BRANCH) begin
            ck_free[e_ckpt[head_idx]] = 1'b1;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (kill[i] && e_kind[i] == OP_BRANCH) begin
                ck_free[e_ckpt[i]] = 1'b1;
            end
        end
    end

    always_comb begin
        head_d = retire_fire ? ptr_inc(head_q) : head_q;
        if (flush) begin
            tail_d = ptr_inc({br_wrap, cmpl_idx});
        end else if (alloc_fire) begin
            tail_d = ptr_inc(tail_q);
        end else begin
            tail_d = tail_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
        end
    end

    // ---------------- slot storage ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= '0;
            e_done  <= '0;
            e_mis   <= '0;
            e_kind  <= '{default: OP_REG};
            e_areg  <= '0;
            e_ptag  <= '0;
            e_prev  <= '0;
            e_ckpt  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_fire && tail_idx == IW'(i)) begin
                    e_valid[i] <= 1'b1;
                    e_done[i]  <= 1'b0;
                    e_mis[i]   <= 1'b0;
                    e_kind[i]  <= op_kind_e'(alloc_kind);
                    e_areg[i]  <= alloc_areg;
                    e_ptag[i]  <= alloc_ptag;
                    e_prev[i]  <= ren_prev;
                    e_ckpt[i]  <= ck_slot;
                end else begin
                    if (kill[i] || (retire_fire && head_idx == IW'(i))) begin
                        e_valid[i] <= 1'b0;
                    end
                    if (cmpl_live && cmpl_idx == IW'(i)) begin
                        e_done[i] <= 1'b1;
                        e_mis[i]  <= cmpl_mispred;
                    end
                end
            end
        end
    end

    // ---------------- sub-blocks ----------------
    rob_ckpt_pool #(
        .NCKPT(NCKPT),
        .CW   (CW)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (alloc_fire && is_branch_req),
        .free_mask(ck_free),
        .avail    (ck_avail),
        .slot     (ck_slot)
    );

    rob_rename_maps #(
        .AREGS (AREGS),
        .PTAG_W(PTAG_W),
        .NCKPT (NCKPT),
        .AW    (AW),
        .CW    (CW)
    ) u_maps (
        .clk         (clk),
        .rst_n       (rst_n),
        .ren_en      (alloc_fire && alloc_kind == 2'(OP_REG)),
        .ren_areg    (alloc_areg),
        .ren_ptag    (alloc_ptag),
        .ren_prev    (ren_prev),
        .save_en     (alloc_fire && is_branch_req),
        .save_slot   (ck_slot),
        .restore_en  (flush),
        .restore_slot(e_ckpt[cmpl_idx]),
        .cmt_en      (retire_fire && e_kind[head_idx] == OP_REG),
        .cmt_areg    (e_areg[head_idx]),
        .cmt_ptag    (e_ptag[head_idx]),
        .spec_rd_areg(spec_rd_areg),
        .spec_rd_ptag(spec_rd_ptag),
        .cmt_rd_areg (cmt_rd_areg),
        .cmt_rd_ptag (cmt_rd_ptag)
    );

    // ---------------- outputs ----------------
    always_comb begin
        alloc_idx        = tail_idx;
        retire_valid     = retire_fire;
        retire_kind      = 2'(e_kind[head_idx]);
        retire_areg      = e_areg[head_idx];
        retire_ptag      = e_ptag[head_idx];
        retire_prev_ptag = e_prev[head_idx];
        retire_mispred   = e_mis[head_idx];
        mem_wr_en        = retire_fire && (e_kind[head_idx] == OP_STORE);
        mem_wr_idx       = head_idx;
        flush_out        = flush;
    end
endmodule

// File: rtl/rob_recover_chk.sv
module rob_recover_chk #(
    parameter int DEPTH  = 6,
    parameter int PTAG_W = 4,
    parameter int AW     = 3,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = IW + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_ready,
    input logic              flush,
    input logic              retire_valid,
    input logic [1:0]        retire_kind,
    input logic              mem_wr_en,
    input logic [IW-1:0]     cmpl_idx,
    input logic [PW-1:0]     head_q,
    input logic [PW-1:0]     tail_q,
    input logic [AW-1:0]     cmt_rd_areg,
    input logic [PTAG_W-1:0] cmt_rd_ptag
);
    logic [PW:0]   occ;
    logic [IW-1:0] after_br;

    always_comb begin
        if (head_q[IW] == tail_q[IW]) begin
            occ = {1'b0, tail_q} - {1'b0, head_q};
        end else begin
            occ = ({2'b0, tail_q[IW-1:0]} + (PW+1)'(DEPTH)) - {2'b0, head_q[IW-1:0]};
        end
        after_br = (cmpl_idx == IW'(DEPTH - 1)) ? '0 : cmpl_idx + IW'(1);
    end

    a_r10_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, head_q[IW-1:0]} < PW'(DEPTH)) && ({1'b0, tail_q[IW-1:0]} < PW'(DEPTH)));

    a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (PW+1)'(DEPTH));

    a_r10_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == (PW+1)'(DEPTH)) |-> !alloc_ready);

    a_r4_store_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (retire_valid && retire_kind == 2'd2));

    a_r6_flush_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_ready);

    a_r5_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tail_q[IW-1:0] == $past(after_br)));

    a_r3_head_moves: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> (head_q != $past(head_q)));

    a_r7_cmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(retire_valid) && $stable(cmt_rd_areg)) |-> $stable(cmt_rd_ptag));
endmodule

bind rob_recover rob_recover_chk #(
    .DEPTH (DEPTH),
    .PTAG_W(PTAG_W),
    .AW    (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .flush       (flush),
    .retire_valid(retire_valid),
    .retire_kind (retire_kind),
    .mem_wr_en   (mem_wr_en),
    .cmpl_idx    (cmpl_idx),
    .head_q      (head_q),
    .tail_q      (tail_q),
    .cmt_rd_areg (cmt_rd_areg),
    .cmt_rd_ptag (cmt_rd_ptag)
);

// File: tb/rob_recover_tb.sv
module rob_recover_tb;
    localparam int DEPTH = 6, AREGS = 8, PTAG_W = 4, NCKPT = 2;
    localparam int IW = 3, AW = 3;
    localparam int K_REG = 0, K_BR = 1, K_ST = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, cmpl_valid = 0, cmpl_mispred = 0;
    logic [1:0] alloc_kind = 0;
    logic [AW-1:0] alloc_areg = 0, spec_rd_areg = 0, cmt_rd_areg = 0;
    logic [PTAG_W-1:0] alloc_ptag = 0;
    logic [IW-1:0] cmpl_idx = 0;
    logic alloc_ready, retire_valid, retire_mispred, mem_wr_en, flush_out;
    logic [IW-1:0] alloc_idx, mem_wr_idx;
    logic [1:0] retire_kind;
    logic [AW-1:0] retire_areg;
    logic [PTAG_W-1:0] retire_ptag, retire_prev_ptag, spec_rd_ptag, cmt_rd_ptag;

    always #10 clk = ~clk;

    rob_recover u_dut (.*);

    int n_chk = 0, n_bad = 0, n_mem = 0;
    bit finished = 0;
    int m_head, m_tail, m_cnt;
    bit m_v[DEPTH], m_d[DEPTH], m_mis[DEPTH];
    int m_kind[DEPTH], m_areg[DEPTH], m_ptag[DEPTH], m_prev[DEPTH];
    int m_spec[AREGS], m_cmt[AREGS];
    int m_ck[DEPTH][AREGS];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_age(input int i);
        return (i - m_head + DEPTH) % DEPTH;
    endfunction

    function automatic int m_branches();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_kind[i] == K_BR) n++;
        return n;
    endfunction

    task automatic idle_inputs();
        alloc_valid = 0; cmpl_valid = 0; cmpl_mispred = 0; alloc_kind = 2'(K_REG);
    endtask

    task automatic step(input bit cv, input int ci, input bit cm,
                        input bit av, input int ak, input int aa, input int ap);
        bit fl, rdy, rv, live;
        int sa, ca;
        cmpl_valid = cv; cmpl_idx = IW'(ci); cmpl_mispred = cm;
        alloc_valid = av; alloc_kind = 2'(ak); alloc_areg = AW'(aa); alloc_ptag = PTAG_W'(ap);
        sa = int'($urandom % AREGS); ca = int'($urandom % AREGS);
        spec_rd_areg = AW'(sa); cmt_rd_areg = AW'(ca);
        #1;
        live = cv && ci < DEPTH && m_v[ci];
        fl   = live && cm && m_kind[ci] == K_BR;
        rdy  = m_cnt < DEPTH && !fl && (ak != K_BR || m_branches() < NCKPT);
        check(alloc_ready == rdy, "R2", "alloc_ready", int'(alloc_ready), int'(rdy));
        check(flush_out == fl, "R5", "flush_out", int'(flush_out), int'(fl));
        if (rdy) check(int'(alloc_idx) == m_tail, "R2", "alloc_idx", int'(alloc_idx), m_tail);
        rv = m_v[m_head] && m_d[m_head];
        check(retire_valid == rv, "R3", "retire_valid", int'(retire_valid), int'(rv));
        if (rv) begin
            check(int'(retire_kind) == m_kind[m_head], "R3", "retire_kind", int'(retire_kind), m_kind[m_head]);
            check(retire_mispred == m_mis[m_head], "R3", "retire_mispred", int'(retire_mispred), int'(m_mis[m_head]));
            if (m_kind[m_head] == K_REG) begin
                check(int'(retire_areg) == m_areg[m_head], "R3", "retire_areg", int'(retire_areg), m_areg[m_head]);
                check(int'(retire_ptag) == m_ptag[m_head], "R3", "retire_ptag", int'(retire_ptag), m_ptag[m_head]);
                check(int'(retire_prev_ptag) == m_prev[m_head], "R3", "retire_prev", int'(retire_prev_ptag), m_prev[m_head]);
            end
        end
        check(mem_wr_en == (rv && m_kind[m_head] == K_ST), "R4", "mem_wr_en",
              int'(mem_wr_en), int'(rv && m_kind[m_head] == K_ST));
        if (mem_wr_en) begin
            n_mem++;
            check(int'(mem_wr_idx) == m_head, "R4", "mem_wr_idx", int'(mem_wr_idx), m_head);
        end
        check(int'(spec_rd_ptag) == m_spec[sa], "R6", "spec map", int'(spec_rd_ptag), m_spec[sa]);
        check(int'(cmt_rd_ptag) == m_cmt[ca], "R7", "committed map", int'(cmt_rd_ptag), m_cmt[ca]);
        // model update for the coming edge
        if (fl) begin
            for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_age(i) > m_age(ci)) m_v[i] = 0;
            m_cnt  = m_age(ci) + 1;
            m_tail = (ci + 1) % DEPTH;
            for (int a = 0; a < AREGS; a++) m_spec[a] = m_ck[ci][a];
        end
        if (live) begin m_d[ci] = 1; m_mis[ci] = cm; end
        if (rv) begin
            m_v[m_head] = 0;
            if (m_kind[m_head] == K_REG) m_cmt[m_areg[m_head]] = m_ptag[m_head];
            m_head = (m_head + 1) % DEPTH;
            m_cnt--;
        end
        if (av && rdy) begin
            m_v[m_tail] = 1; m_d[m_tail] = 0; m_mis[m_tail] = 0;
            m_kind[m_tail] = ak; m_areg[m_tail] = aa; m_ptag[m_tail] = ap;
            m_prev[m_tail] = m_spec[aa];
            if (ak == K_REG) m_spec[aa] = ap;
            if (ak == K_BR) for (int a = 0; a < AREGS; a++) m_ck[m_tail][a] = m_spec[a];
            m_tail = (m_tail + 1) % DEPTH;
            m_cnt++;
        end
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic drain();
        for (int k = 0; k < 60; k++) begin
            if (m_cnt == 0) break;
            if (m_v[m_head] && !m_d[m_head]) step(1, m_head, 0, 0, K_REG, 0, 0);
            else step(0, 0, 0, 0, K_REG, 0, 0);
        end
        check(m_cnt == 0, "R3", "drain finished", m_cnt, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        int i0, i1, i2, i3, mem0;
        void'($urandom(32'd2024));
        m_head = 0; m_tail = 0; m_cnt = 0;
        for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_d[i] = 0; m_mis[i] = 0; end
        for (int a = 0; a < AREGS; a++) begin m_spec[a] = a; m_cmt[a] = a; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        idle_inputs();
        for (int a = 0; a < AREGS; a++) begin
            spec_rd_areg = AW'(a); cmt_rd_areg = AW'(a); #1;
            check(int'(spec_rd_ptag) == a, "R1", "spec identity", int'(spec_rd_ptag), a);
            check(int'(cmt_rd_ptag) == a, "R1", "cmt identity", int'(cmt_rd_ptag), a);
        end
        check(alloc_ready == 1, "R1", "ready after reset", int'(alloc_ready), 1);
        check(retire_valid == 0, "R1", "no retire after reset", int'(retire_valid), 0);
        check(mem_wr_en == 0, "R1", "no store after reset", int'(mem_wr_en), 0);

        // R10/R2: fill to full
        for (int k = 0; k < DEPTH; k++) step(0, 0, 0, 1, K_REG, k, k + 1);
        #1;
        check(alloc_ready == 0, "R10", "full refuses", int'(alloc_ready), 0);
        check(retire_valid == 0, "R10", "full is not empty-retire", int'(retire_valid), 0);
        step(1, 2, 0, 0, K_REG, 0, 0);
        #1;
        check(retire_valid == 0, "R3", "head not done", int'(retire_valid), 0);
        drain();

        // R9: snapshot exhaustion
        step(0, 0, 0, 1, K_BR, 0, 0);
        step(0, 0, 0, 1, K_BR, 0, 0);
        alloc_kind = 2'(K_BR); #1;
        check(alloc_ready == 0, "R9", "branch stalls", int'(alloc_ready), 0);
        alloc_kind = 2'(K_REG); #1;
        check(alloc_ready == 1, "R9", "non-branch proceeds", int'(alloc_ready), 1);
        idle_inputs();
        drain();

        // R5/R6/R4/R8: wrong-path recovery
        mem0 = n_mem;
        i0 = m_tail; step(0, 0, 0, 1, K_REG, 1, 9);
        i1 = m_tail; step(0, 0, 0, 1, K_BR, 0, 0);
        i2 = m_tail; step(0, 0, 0, 1, K_ST, 0, 0);
        i3 = m_tail; step(0, 0, 0, 1, K_REG, 1, 12);
        step(1, i2, 0, 0, K_REG, 0, 0);
        step(1, i1, 1, 0, K_REG, 0, 0);
        spec_rd_areg = 3'd1; #1;
        check(int'(spec_rd_ptag) == 9, "R6", "restored map", int'(spec_rd_ptag), 9);
        check(int'(alloc_idx) == (i1 + 1) % DEPTH, "R5", "tail after branch", int'(alloc_idx), (i1 + 1) % DEPTH);
        step(1, i3, 0, 0, K_REG, 0, 0);
        step(1, i0, 0, 0, K_REG, 0, 0);
        step(0, 0, 0, 0, K_REG, 0, 0);
        step(0, 0, 0, 0, K_REG, 0, 0);
        check(m_cnt == 0, "R5", "older slots retired", m_cnt, 0);
        check(n_mem == mem0, "R4", "wrong-path store silent", n_mem, mem0);
        step(0, 0, 0, 1, K_REG, 2, 5);
        step(0, 0, 0, 0, K_REG, 0, 0);
        #1;
        check(retire_valid == 0, "R8", "reused slot waits", int'(retire_valid), 0);
        step(1, i2, 0, 0, K_REG, 0, 0);
        drain();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            bit cv, cm, av;
            int ci, ak;
            cv = ($urandom % 2) == 0;
            if (($urandom % 4) != 0 && m_cnt > 0) ci = (m_head + int'($urandom % m_cnt)) % DEPTH;
            else ci = int'($urandom % 8);
            cm = ($urandom % 5) == 0;
            av = ($urandom % 10) < 7;
            ak = int'($urandom % 3);
            step(cv, ci, cm, av, ak, int'($urandom % AREGS), int'($urandom % 16));
        end
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule